// File: doc/BRIEF.md
# Dual-Output Configurable Interrupt Controller

This block collects 64 interrupt sources, held as two banks of 32 bits, and merges them onto a normal interrupt line and a fast interrupt line. Each source has its own choice of trigger type (level or edge), sense (high/rising or low/falling) and output route. Every source input passes through a two-flop synchroniser. An edge source latches a pending bit that software clears by writing a one. A level source shows its sense-corrected input directly. A software-forced bit per source is ORed into the raw state.

Software reaches the block over a simple 32-bit register bus with byte addresses. A read request returns its data one cycle later, marked by a valid strobe. The enable bits can be written whole, or set and cleared one bit at a time through write-one ports. A per-output master enable gates each line. A readout gives the number of the lowest-numbered pending normal interrupt.

Top module: `irqc_top`

## Requirements
- R1: After reset every source is level, active-high, routed to the normal line and disabled. Both master enables are 0, irq_o and fiq_o are low, configuration reads return 0, and the pending-number readout returns 0x7F.
- R2: Source n maps to bank n/32, bit n mod 32. Each register group holds bank 0 at its base and bank 1 at base+4. The group bases are: route 0x00, enable 0x10, enable-clear 0x20, enable-set 0x30, trigger type 0x40, sense 0x50, normal status 0x80, fast status 0x90, raw 0xA0, pending-clear 0xB0 and soft 0xC0. The master enable is at 0x64 and the pending number at 0xD0. A read request at a clock edge gives rdata_o with rvalid_o high after that edge.
- R3: A write to enable-set sets each enable bit whose data bit is 1, and a write to enable-clear clears each such bit. Zero data bits leave their enable bits unchanged. A write to the enable group replaces the bank. Enable-set and enable-clear read as 0.
- R4: For a level source with sense bit 0, the raw bit equals the synchronised input. With sense bit 1, the raw bit is the inverse of that input.
- R5: For an edge source (type bit 1), a rising input edge with sense 0, or a falling input edge with sense 1, latches the raw bit to 1. The bit stays at 1 after the input returns. The opposite edge latches nothing.
- R6: Writing 1 to a pending-clear bit clears the latched bit of an edge source. On a level source such a write has no effect.
- R7: A soft bit set to 1 forces the raw bit of its source to 1.
- R8: The normal status is raw AND enable AND NOT route. The fast status is raw AND enable AND route, where route bit 1 selects the fast line.
- R9: irq_o is master bit 0 AND the OR of the normal status. fiq_o is master bit 1 AND the OR of the fast status. The status registers themselves are not gated by the master enables.
- R10: The pending-number readout gives the lowest source index with a normal status bit set while master bit 0 is 1. Otherwise it gives 0x7F.
- R11: A change on a level input reaches irq_o after the second rising clock edge and not after the first. An edge event reaches irq_o after the third rising clock edge.
- R12: Writes to read-only or unmapped offsets, or to a bank that does not exist, change no state. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Asynchronous interrupt source inputs |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data strobe, one cycle after a read request |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
A wrong latched edge bit shows at irq_o within one cycle, and again in the raw view the next time it is read. A bad enable or route bit moves a source between the two status views and the two lines as soon as that source becomes active. A wrong priority choice shows only at the next pending-number read, so the bench reads that number with several sources active at once. A synchroniser that is too short or too long moves the output change by one edge, so the bench samples irq_o after each single edge that follows a change on an input.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned BANK_W = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned ID_W   = 7;
  localparam logic [ID_W-1:0] ID_NONE = 7'h7F;

  // address bits [7:4] select the register group
  localparam logic [3:0] GRP_ROUTE = 4'h0;
  localparam logic [3:0] GRP_EN    = 4'h1;
  localparam logic [3:0] GRP_ENCLR = 4'h2;
  localparam logic [3:0] GRP_ENSET = 4'h3;
  localparam logic [3:0] GRP_TYPE  = 4'h4;
  localparam logic [3:0] GRP_SENSE = 4'h5;
  localparam logic [3:0] GRP_IRQST = 4'h8;
  localparam logic [3:0] GRP_FIQST = 4'h9;
  localparam logic [3:0] GRP_RAW   = 4'hA;
  localparam logic [3:0] GRP_CLR   = 4'hB;
  localparam logic [3:0] GRP_SOFT  = 4'hC;

  localparam logic [ADDR_W-1:0] ADR_MASTER = 8'h64;
  localparam logic [ADDR_W-1:0] ADR_PENDID = 8'hD0;
endpackage

// File: rtl/irqc_src.sv
module irqc_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic edge_i,
  input  logic low_i,
  input  logic clr_i,
  output logic raw_o
);
  logic s1, s2, s3, pend, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= src_i;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign hit = low_i ? (s3 & ~s2) : (s2 & ~s3);

  // a new edge wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend <= 1'b0;
    else if (!edge_i) pend <= 1'b0;
    else if (hit)     pend <= 1'b1;
    else if (clr_i)   pend <= 1'b0;
  end

  assign raw_o = edge_i ? pend : (s2 ^ low_i);

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend && edge_i && !clr_i |=> pend);  // R5
  AST_LEVEL_NO_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_i |=> !pend);  // R6
endmodule

// File: rtl/irqc_lowest.sv
module irqc_lowest #(
  parameter int unsigned N   = 64,
  parameter int unsigned IDW = 7
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   vec_i,
  output logic           any_o,
  output logic [IDW-1:0] idx_o
);
  localparam int unsigned LW = (N > 1) ? $clog2(N) : 1;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDW'(i);
    end
  end
  assign any_o = |vec_i;

  AST_LOWEST_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> vec_i[idx_o[LW-1:0]]);  // R10
  AST_LOWEST_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> ((vec_i & ~({N{1'b1}} << idx_o)) == '0));  // R10
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_BANKS*32-1:0]  src_i,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [7:0]               addr_i,
  input  logic [31:0]              wdata_i,
  output logic [31:0]              rdata_o,
  output logic                     rvalid_o,
  output logic                     irq_o,
  output logic                     fiq_o
);
  localparam int unsigned NSRC = NUM_BANKS * BANK_W;

  logic [NSRC-1:0] route_q, en_q, type_q, sense_q, soft_q;
  logic [NSRC-1:0] clr, cell_raw, raw, irq_st, fiq_st;
  logic [1:0]      master_q;
  logic [3:0]      grp;
  logic [1:0]      bank;
  logic            aligned, wr, rd;
  logic            pend_any;
  logic [ID_W-1:0] pend_idx, pend_id;
  logic [31:0]     rd_d;

  assign grp     = addr_i[7:4];
  assign bank    = addr_i[3:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr      = req_i && we_i && aligned;
  assign rd      = req_i && !we_i;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign clr[b*BANK_W +: BANK_W] =
      (wr && grp == GRP_CLR && bank == 2'(b)) ? wdata_i : '0;
  end

  for (genvar n = 0; n < NSRC; n++) begin : g_src
    irqc_src u_src (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .src_i (src_i[n]),
      .edge_i(type_q[n]),
      .low_i (sense_q[n]),
      .clr_i (clr[n]),
      .raw_o (cell_raw[n])
    );
  end

  assign raw    = cell_raw | soft_q;
  assign irq_st = raw & en_q & ~route_q;
  assign fiq_st = raw & en_q & route_q;
  assign irq_o  = master_q[0] & (|irq_st);
  assign fiq_o  = master_q[1] & (|fiq_st);

  irqc_lowest #(.N(NSRC), .IDW(ID_W)) u_lowest (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vec_i (master_q[0] ? irq_st : '0),
    .any_o (pend_any),
    .idx_o (pend_idx)
  );
  assign pend_id = pend_any ? pend_idx : ID_NONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_q  <= '0;
      en_q     <= '0;
      type_q   <= '0;
      sense_q  <= '0;
      soft_q   <= '0;
      master_q <= '0;
    end else if (wr) begin
      if (addr_i == ADR_MASTER) master_q <= wdata_i[1:0];
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bank == 2'(b)) begin
          case (grp)
            GRP_ROUTE: route_q[b*BANK_W +: BANK_W] <= wdata_i;
            GRP_EN:    en_q[b*BANK_W +: BANK_W]    <= wdata_i;
            GRP_ENCLR: en_q[b*BANK_W +: BANK_W]    <= en_q[b*BANK_W +: BANK_W] & ~wdata_i;
            GRP_ENSET: en_q[b*BANK_W +: BANK_W]    <= en_q[b*BANK_W +: BANK_W] | wdata_i;
            GRP_TYPE:  type_q[b*BANK_W +: BANK_W]  <= wdata_i;
            GRP_SENSE: sense_q[b*BANK_W +: BANK_W] <= wdata_i;
            GRP_SOFT:  soft_q[b*BANK_W +: BANK_W]  <= wdata_i;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_d = '0;
    if (aligned) begin
      if (addr_i == ADR_MASTER) rd_d = {30'b0, master_q};
      if (addr_i == ADR_PENDID) rd_d = {{(32-ID_W){1'b0}}, pend_id};
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bank == 2'(b)) begin
          case (grp)
            GRP_ROUTE: rd_d = route_q[b*BANK_W +: BANK_W];
            GRP_EN:    rd_d = en_q[b*BANK_W +: BANK_W];
            GRP_TYPE:  rd_d = type_q[b*BANK_W +: BANK_W];
            GRP_SENSE: rd_d = sense_q[b*BANK_W +: BANK_W];
            GRP_IRQST: rd_d = irq_st[b*BANK_W +: BANK_W];
            GRP_FIQST: rd_d = fiq_st[b*BANK_W +: BANK_W];
            GRP_RAW:   rd_d = raw[b*BANK_W +: BANK_W];
            GRP_SOFT:  rd_d = soft_q[b*BANK_W +: BANK_W];
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd;
      rdata_o  <= rd ? rd_d : '0;
    end
  end

  AST_RVALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i));  // R2
  AST_ENSET_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && grp == GRP_ENSET && bank == 2'd0 |=>
      ((en_q[BANK_W-1:0] & $past(wdata_i)) == $past(wdata_i)));  // R3
  AST_ENCLR_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && grp == GRP_ENCLR && bank == 2'd0 |=>
      ((en_q[BANK_W-1:0] & $past(wdata_i)) == '0));  // R3
  AST_MASTER_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_q[0] && !master_q[1] |-> !irq_o && !fiq_o);  // R9
endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] srcs = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, irq, fiq;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #5 clk = ~clk;

  irqc_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(srcs),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_q.size() == 0) check("R2 unexpected rvalid", 32'h1, 32'h0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 irq_o", {31'b0, irq}, 32'h0);
    check("R1 fiq_o", {31'b0, fiq}, 32'h0);
    rd(8'h10, 32'h0, "R1 enable");
    rd(8'h00, 32'h0, "R1 route");
    rd(8'h40, 32'h0, "R1 type");
    rd(8'hD0, 32'h7F, "R1 pend id");

    // R3 enable set/clear, R2 bank mapping
    wr(8'h64, 32'h3);
    wr(8'h30, 32'h10);
    rd(8'h10, 32'h10, "R3 enset");
    wr(8'h34, 32'h1);
    rd(8'h14, 32'h1, "R2 bank1 enable");
    wr(8'h20, 32'h10);
    rd(8'h10, 32'h0, "R3 enclr");
    wr(8'h10, 32'hFF);
    rd(8'h10, 32'hFF, "R3 direct");
    wr(8'h30, 32'h100);
    rd(8'h10, 32'h1FF, "R3 zero bits keep");
    rd(8'h30, 32'h0, "R3 enset reads 0");

    // R11 / R4 level high
    srcs[3] = 1'b1;
    tick(1);
    check("R11 level one edge", {31'b0, irq}, 32'h0);
    tick(1);
    check("R11 level two edges", {31'b0, irq}, 32'h1);
    rd(8'hA0, 32'h8, "R4 raw level");
    rd(8'h80, 32'h8, "R8 irq status");
    rd(8'hD0, 32'h3, "R10 pend id src3");
    srcs[3] = 1'b0;
    tick(3);
    check("R4 level drop", {31'b0, irq}, 32'h0);

    // R4 active low
    wr(8'h50, 32'h4);
    tick(3);
    rd(8'hA0, 32'h4, "R4 active low");
    rd(8'hD0, 32'h2, "R10 pend id src2");
    srcs[2] = 1'b1;
    tick(3);
    rd(8'hA0, 32'h0, "R4 active low idle");
    srcs[2] = 1'b0;
    wr(8'h50, 32'h0);
    tick(3);

    // R5 rising edge, R11 edge latency
    wr(8'h40, 32'h20);
    srcs[5] = 1'b1;
    tick(2);
    check("R11 edge two edges", {31'b0, irq}, 32'h0);
    tick(1);
    check("R11 edge three edges", {31'b0, irq}, 32'h1);
    srcs[5] = 1'b0;
    tick(4);
    check("R5 latched after drop", {31'b0, irq}, 32'h1);
    rd(8'hA0, 32'h20, "R5 raw latched");
    wr(8'hB0, 32'h20);
    check("R6 clear irq_o", {31'b0, irq}, 32'h0);
    rd(8'hA0, 32'h0, "R6 clear raw");

    // R5 falling edge
    wr(8'h50, 32'h20);
    srcs[5] = 1'b1;
    tick(4);
    rd(8'hA0, 32'h0, "R5 rising ignored when falling");
    srcs[5] = 1'b0;
    tick(4);
    rd(8'hA0, 32'h20, "R5 falling latched");
    wr(8'hB0, 32'h20);
    wr(8'h40, 32'h0);
    wr(8'h50, 32'h0);
    tick(3);

    // R6 clear on level source
    srcs[3] = 1'b1;
    tick(3);
    wr(8'hB0, 32'h8);
    rd(8'hA0, 32'h8, "R6 level unaffected");
    srcs[3] = 1'b0;
    tick(3);

    // R7 soft, R8 routing
    wr(8'hC4, 32'h2);
    rd(8'hA4, 32'h2, "R7 soft raw");
    rd(8'h84, 32'h0, "R8 disabled no status");
    wr(8'h34, 32'h2);
    rd(8'h84, 32'h2, "R8 irq status bank1");
    rd(8'hD0, 32'h21, "R10 pend id src33");
    check("R8 irq_o", {31'b0, irq}, 32'h1);
    wr(8'h04, 32'h2);
    rd(8'h84, 32'h0, "R8 rerouted irq st");
    rd(8'h94, 32'h2, "R8 fiq status");
    check("R8 irq_o off", {31'b0, irq}, 32'h0);
    check("R8 fiq_o on", {31'b0, fiq}, 32'h1);
    rd(8'hD0, 32'h7F, "R10 none on irq");

    // R9 master gating
    wr(8'h64, 32'h1);
    check("R9 fiq gated", {31'b0, fiq}, 32'h0);
    rd(8'h94, 32'h2, "R9 status ungated");
    wr(8'h04, 32'h0);
    check("R9 irq on", {31'b0, irq}, 32'h1);
    wr(8'h64, 32'h2);
    check("R9 irq gated", {31'b0, irq}, 32'h0);
    rd(8'hD0, 32'h7F, "R10 gated by master");
    rd(8'h64, 32'h2, "R2 master readback");

    // R10 lowest wins
    wr(8'h64, 32'h3);
    wr(8'hC0, 32'h80);
    rd(8'hD0, 32'h7, "R10 lowest index");

    // R12 ignored writes
    wr(8'h70, 32'hFFFF_FFFF);
    rd(8'h70, 32'h0, "R12 unmapped read");
    wr(8'hA0, 32'h0);
    rd(8'hA0, 32'h80, "R12 raw read-only");
    wr(8'h08, 32'hFF);
    rd(8'h08, 32'h0, "R12 missing bank");
    rd(8'h00, 32'h0, "R12 route untouched");
    rd(8'hD0, 32'h7, "R12 pend id unchanged");

    tick(3);
    check("R2 all reads returned", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule